// File: doc/BRIEF.md
# FEAC Codeword Receive Detector

This block watches a serial bit stream, one bit per strobe, for 16-bit far-end alarm and control codewords. It locks onto the alignment pattern of eight consecutive ones, then an opening zero. It takes the next six bits as the payload and checks that a closing zero follows. A good codeword hands its six-bit payload to an integrator.

The integrator keeps a sliding window of the most recent codewords. It accepts a payload only when that payload fills enough of the window. Accepted payloads are queued in a small FIFO, which the host drains one entry per read strobe. The host sees the head entry, an empty flag and a sticky overflow flag.

Line deframing is out of scope. The stream arrives already extracted, with a strobe marking each valid bit.

Top module: `feac_rx_detector`

## Requirements
- R1: A codeword is recognised as, in arrival order, at least eight 1 bits, a 0, six payload bits and a closing 0. A run of more than eight ones before the opening 0 still aligns.
- R2: The first payload bit received becomes bit 0 of the stored value and the last becomes bit 5.
- R3: If the bit in the closing position is 1, the candidate is discarded, the search for eight ones restarts from zero, and the integration window and the repeat lock are both cleared.
- R4: A payload is accepted when it equals at least 8 of the last 10 good codewords, counting the one just received. With fewer matches, nothing is queued.
- R5: Once a value is accepted, it is not queued again until a codeword with a different payload arrives or a discard per R3 occurs.
- R6: The FIFO holds 4 entries and returns them in acceptance order on `data_o`.
- R7: An acceptance while the FIFO holds 4 entries is dropped and sets `ovf_o`. `ovf_o` stays set until reset.
- R8: A high `rd_i` removes the head entry. When the FIFO is empty, `data_o` reads 0, and a read leaves the FIFO empty and unchanged.
- R9: After reset, `empty_o` is 1, `data_o` is 0 and `ovf_o` is 0.
- R10: `bit_i` is sampled only in cycles where `bit_vld_i` is high. Values on `bit_i` in other cycles have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial data bit |
| bit_vld_i | input | 1 | Strobe qualifying `bit_i` |
| rd_i | input | 1 | Pops the FIFO head |
| data_o | output | 6 | FIFO head payload, LSB first-received |
| empty_o | output | 1 | FIFO empty |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The stream is tested in several forms:
- Codewords preceded by long runs of ones, which test alignment.
- An asymmetric payload value, which exposes a reversed bit order.
- Runs of seven against eight identical codewords, which pin the acceptance threshold.
- A discard between two runs of seven. This tells a window that is cleared apart from one that keeps counting.
- Long repeats, and a single different codeword followed by the original value. These show whether the repeat lock blocks and releases correctly.

Five distinct accepted values with no reads exercise overflow. Random mixes of a few payloads, strobe gaps with noise on the data bit, and occasional bad closing bits are checked against a bench model of the window.

// File: rtl/feac_rx_pkg.sv
package feac_rx_pkg;
  localparam int unsigned PAY_W   = 6;
  localparam int unsigned SYNC_N  = 8;
  localparam int unsigned SYNC_CW = $clog2(SYNC_N + 1);
  localparam int unsigned PIDX_W  = $clog2(PAY_W);

  typedef logic [PAY_W-1:0] payload_t;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_DATA  = 2'd1,
    ST_CLOSE = 2'd2
  } frm_state_e;
endpackage

// File: rtl/feac_rx_framer.sv
module feac_rx_framer
  import feac_rx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     bit_i,
  input  logic     bit_vld_i,
  output logic     cw_vld_o,
  output logic     cw_loss_o,
  output payload_t cw_data_o
);
  frm_state_e             state_q;
  logic [SYNC_CW-1:0]     ones_q;
  logic [PIDX_W-1:0]      idx_q;
  payload_t               sh_q;

  localparam logic [SYNC_CW-1:0] ONES_MAX = SYNC_CW'(SYNC_N);
  localparam logic [PIDX_W-1:0]  IDX_LAST = PIDX_W'(PAY_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_HUNT;
      ones_q    <= '0;
      idx_q     <= '0;
      sh_q      <= '0;
      cw_vld_o  <= 1'b0;
      cw_loss_o <= 1'b0;
      cw_data_o <= '0;
    end else begin
      cw_vld_o  <= 1'b0;
      cw_loss_o <= 1'b0;
      if (bit_vld_i) begin
        unique case (state_q)
          ST_HUNT: begin
            if (bit_i) begin
              if (ones_q != ONES_MAX) ones_q <= ones_q + 1'b1;
            end else begin
              if (ones_q == ONES_MAX) begin
                state_q <= ST_DATA;
                idx_q   <= '0;
              end
              ones_q <= '0;
            end
          end
          ST_DATA: begin
            // first bit ends up at LSB after PAY_W shifts
            sh_q  <= {bit_i, sh_q[PAY_W-1:1]};
            idx_q <= idx_q + 1'b1;
            if (idx_q == IDX_LAST) state_q <= ST_CLOSE;
          end
          ST_CLOSE: begin
            if (!bit_i) begin
              cw_vld_o  <= 1'b1;
              cw_data_o <= sh_q;
            end else begin
              cw_loss_o <= 1'b1;
            end
            state_q <= ST_HUNT;
            ones_q  <= '0;
          end
          default: begin
            state_q <= ST_HUNT;
            ones_q  <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/feac_rx_integrator.sv
module feac_rx_integrator
  import feac_rx_pkg::*;
#(
  parameter int unsigned WIN    = 10,
  parameter int unsigned THRESH = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cw_vld_i,
  input  logic     cw_loss_i,
  input  payload_t cw_data_i,
  output logic     acc_vld_o,
  output payload_t acc_data_o
);
  localparam int unsigned CNT_W = $clog2(WIN + 1);
  localparam logic [CNT_W-1:0] THR = CNT_W'(THRESH);

  payload_t         hist_q [WIN];
  logic [WIN-1:0]   hv_q;
  logic             lock_q;
  payload_t         lock_val_q;
  logic [CNT_W-1:0] match_cnt;
  logic             same_lock;
  logic             accept;

  // count the new codeword plus matches among the WIN-1 previous ones
  always_comb begin
    match_cnt = CNT_W'(1);
    for (int i = 0; i < int'(WIN) - 1; i++) begin
      if (hv_q[i] && (hist_q[i] == cw_data_i)) match_cnt = match_cnt + 1'b1;
    end
  end

  assign same_lock = lock_q && (lock_val_q == cw_data_i);
  assign accept    = cw_vld_i && (match_cnt >= THR) && !same_lock;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hv_q       <= '0;
      lock_q     <= 1'b0;
      lock_val_q <= '0;
      acc_vld_o  <= 1'b0;
      acc_data_o <= '0;
    end else begin
      acc_vld_o <= 1'b0;
      if (cw_loss_i) begin
        hv_q   <= '0;
        lock_q <= 1'b0;
      end else if (cw_vld_i) begin
        hv_q <= {hv_q[WIN-2:0], 1'b1};
        if (accept) begin
          lock_q     <= 1'b1;
          lock_val_q <= cw_data_i;
          acc_vld_o  <= 1'b1;
          acc_data_o <= cw_data_i;
        end else if (!same_lock) begin
          lock_q <= 1'b0;
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < int'(WIN); g++) begin : g_hist
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          hist_q[g] <= '0;
        end else if (cw_vld_i && !cw_loss_i) begin
          if (g == 0) hist_q[g] <= cw_data_i;
          else        hist_q[g] <= hist_q[(g == 0) ? 0 : g - 1];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/feac_rx_fifo.sv
module feac_rx_fifo
  import feac_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     push_i,
  input  payload_t push_data_i,
  input  logic     pop_i,
  output payload_t head_o,
  output logic     empty_o,
  output logic     full_o,
  output logic     ovf_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  payload_t      mem_q [DEPTH];
  logic [AW:0]   wr_q, rd_q;
  logic          push_ok, pop_ok;

  assign empty_o = (wr_q == rd_q);
  assign full_o  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign head_o  = empty_o ? '0 : mem_q[rd_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (push_ok) wr_q <= wr_q + 1'b1;
      if (pop_ok)  rd_q <= rd_q + 1'b1;
      if (push_i && full_o) ovf_o <= 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < int'(DEPTH); g++) begin : g_mem
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mem_q[g] <= '0;
        else if (push_ok && (wr_q[AW-1:0] == AW'(g))) mem_q[g] <= push_data_i;
      end
    end
  endgenerate
endmodule

// File: rtl/feac_rx_detector.sv
module feac_rx_detector
  import feac_rx_pkg::*;
#(
  parameter int unsigned WIN    = 10,
  parameter int unsigned THRESH = 8,
  parameter int unsigned DEPTH  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             bit_vld_i,
  input  logic             rd_i,
  output logic [PAY_W-1:0] data_o,
  output logic             empty_o,
  output logic             ovf_o
);
  logic     cw_vld, cw_loss, acc_vld, fifo_full;
  payload_t cw_data, acc_data;

  feac_rx_framer u_frm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_i     (bit_i),
    .bit_vld_i (bit_vld_i),
    .cw_vld_o  (cw_vld),
    .cw_loss_o (cw_loss),
    .cw_data_o (cw_data)
  );

  feac_rx_integrator #(.WIN(WIN), .THRESH(THRESH)) u_int (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cw_vld_i   (cw_vld),
    .cw_loss_i  (cw_loss),
    .cw_data_i  (cw_data),
    .acc_vld_o  (acc_vld),
    .acc_data_o (acc_data)
  );

  feac_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (acc_vld),
    .push_data_i (acc_data),
    .pop_i       (rd_i),
    .head_o      (data_o),
    .empty_o     (empty_o),
    .full_o      (fifo_full),
    .ovf_o       (ovf_o)
  );
endmodule

// File: rtl/feac_rx_checker.sv
module feac_rx_checker
  import feac_rx_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_i,
  input logic             bit_vld_i,
  input logic             rd_i,
  input logic [PAY_W-1:0] data_o,
  input logic             empty_o,
  input logic             ovf_o,
  input logic             cw_vld,
  input logic             cw_loss,
  input logic             acc_vld,
  input logic             fifo_full
);
  a_r1_close_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_vld |-> ($past(bit_vld_i) && !$past(bit_i)));

  a_r1_good_or_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cw_vld && cw_loss));

  a_r3_loss_on_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_loss |-> ($past(bit_vld_i) && $past(bit_i)));

  a_r4_acc_after_cw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_vld |-> $past(cw_vld));

  a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  a_r7_full_push_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld && fifo_full) |=> ovf_o);

  a_r8_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (data_o == '0));

  a_r8_empty_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && empty_o && !acc_vld) |=> empty_o);

  a_r6_full_not_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_full && empty_o));
endmodule

bind feac_rx_detector feac_rx_checker u_chk (.*);

// File: tb/feac_rx_detector_tb.sv
module feac_rx_detector_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_i = 1'b0;
  logic       bit_vld_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [5:0] data_o;
  logic       empty_o;
  logic       ovf_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench model state
  logic [5:0] m_hist [10];
  logic [9:0] m_hv;
  bit         m_lock;
  logic [5:0] m_lock_val;
  logic [5:0] m_q [$];
  bit         m_ovf;

  always #4 clk_i = ~clk_i;

  feac_rx_detector u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
    .rd_i(rd_i), .data_o(data_o), .empty_o(empty_o), .ovf_o(ovf_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_count(input logic [5:0] v);
    int n = 1;
    for (int i = 0; i < 9; i++) if (m_hv[i] && m_hist[i] == v) n++;
    return n;
  endfunction

  function automatic void model_reset();
    m_hv = '0; m_lock = 0; m_lock_val = '0; m_q.delete(); m_ovf = 0;
    for (int i = 0; i < 10; i++) m_hist[i] = '0;
  endfunction

  function automatic void model_cw(input logic [5:0] v, input bit bad);
    if (bad) begin
      m_hv = '0; m_lock = 0;
      return;
    end
    if (m_lock && m_lock_val != v) m_lock = 0;
    if (model_count(v) >= 8 && !m_lock) begin
      m_lock = 1; m_lock_val = v;
      if (m_q.size() == 4) m_ovf = 1;
      else m_q.push_back(v);
    end
    for (int i = 9; i > 0; i--) m_hist[i] = m_hist[i-1];
    m_hist[0] = v;
    m_hv = {m_hv[8:0], 1'b1};
  endfunction

  task automatic send_bit(input logic b, input bit gaps);
    bit_i = b; bit_vld_i = 1'b1;
    @(negedge clk_i);
    bit_vld_i = 1'b0;
    if (gaps) begin
      int g = $urandom_range(0, 2);
      for (int k = 0; k < g; k++) begin
        bit_i = 1'($urandom);  // R10 noise while strobe low
        @(negedge clk_i);
      end
    end
    bit_i = 1'b0;
  endtask

  task automatic send_cw(input logic [5:0] v, input bit bad, input int extra_ones, input bit gaps);
    for (int k = 0; k < 8 + extra_ones; k++) send_bit(1'b1, gaps);
    send_bit(1'b0, gaps);
    for (int k = 0; k < 6; k++) send_bit(v[k], gaps);
    send_bit(bad, gaps);
    model_cw(v, bad);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_i);
  endtask

  task automatic drain(input string req);
    while (m_q.size() > 0) begin
      chk(empty_o == 1'b0, req, empty_o, 0);
      chk(data_o == m_q[0], req, data_o, m_q[0]);
      rd_i = 1'b1; @(negedge clk_i); rd_i = 1'b0;
      void'(m_q.pop_front());
    end
    chk(empty_o == 1'b1, req, empty_o, 1);
    chk(data_o == 6'd0, req, data_o, 0);
    chk(ovf_o == m_ovf, "R7", ovf_o, m_ovf);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    model_reset();
    @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk_i);
    do_reset();
    // R9 reset state
    chk(empty_o == 1'b1, "R9", empty_o, 1);
    chk(data_o == 6'd0, "R9", data_o, 0);
    chk(ovf_o == 1'b0, "R9", ovf_o, 0);

    // R8 read while empty
    rd_i = 1'b1; @(negedge clk_i); rd_i = 1'b0;
    chk(empty_o == 1'b1 && data_o == 6'd0, "R8", empty_o, 1);

    // R4 seven identical: below threshold
    for (int k = 0; k < 7; k++) send_cw(6'h0B, 0, 0, 0);
    settle();
    chk(empty_o == 1'b1, "R4", empty_o, 1);
    // eighth reaches threshold; R2 bit order with asymmetric 0x0B
    send_cw(6'h0B, 0, 0, 0);
    settle();
    chk(data_o == 6'h0B, "R2", data_o, 6'h0B);
    drain("R4");

    // R5 lock: more repeats not re-queued; change then return re-accepts
    for (int k = 0; k < 6; k++) send_cw(6'h0B, 0, 0, 1);
    settle();
    chk(empty_o == 1'b1, "R5", empty_o, 1);
    send_cw(6'h21, 0, 0, 1);
    send_cw(6'h0B, 0, 0, 1);
    settle();
    drain("R5");

    // R3 discard clears window: 7, bad, 7 -> nothing
    do_reset();
    for (int k = 0; k < 7; k++) send_cw(6'h15, 0, 0, 0);
    send_cw(6'h15, 1, 0, 0);
    for (int k = 0; k < 7; k++) send_cw(6'h15, 0, 0, 0);
    settle();
    chk(empty_o == 1'b1, "R3", empty_o, 1);
    drain("R3");

    // R1 long ones runs, R10 noise in gaps
    do_reset();
    for (int k = 0; k < 8; k++) send_cw(6'h3E, 0, 4, 1);
    settle();
    chk(data_o == 6'h3E, "R1", data_o, 6'h3E);
    chk(data_o == 6'h3E, "R10", data_o, 6'h3E);
    drain("R1");

    // R6 order and R7 overflow: five accepted values, no reads
    do_reset();
    for (int v = 1; v <= 5; v++)
      for (int k = 0; k < 8; k++) send_cw(6'(v * 9), 0, 0, 0);
    settle();
    chk(ovf_o == 1'b1, "R7", ovf_o, 1);
    drain("R6");
    do_reset();
    chk(ovf_o == 1'b0, "R7", ovf_o, 0);

    // random mix
    for (int r = 0; r < 30; r++) begin
      int n = $urandom_range(4, 16);
      for (int k = 0; k < n; k++) begin
        logic [5:0] v;
        int sel = $urandom_range(0, 9);
        v = (sel < 7) ? 6'h2A : ((sel < 9) ? 6'h13 : 6'(r));
        send_cw(v, ($urandom_range(0, 15) == 0), $urandom_range(0, 2), 1);
      end
      settle();
      if ($urandom_range(0, 1) == 1 || r == 29) drain("R4");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule